// File: doc/BRIEF.md
# Path REI Error Accumulator

This block counts far-end path errors for up to three STS-1/STM-1 channels. Once per frame, each channel hands over its received path status byte together with a valid strobe. The block decodes the remote error indication nibble in the upper half of that byte and adds the result to a per-channel running counter. Each running counter is 16 bits wide by default.

A global mode input selects the counting rule:

- Bit counting adds the decoded number of errored bits.
- Block counting adds one for every frame that reports any error.

A second global input chooses what a counter does at its maximum. It either wraps around or saturates.

An interval pulse arrives from an external performance-monitoring timer. On that pulse the block copies every running count into a holding register, which is the only count it presents, and restarts the running count from zero.

The byte inputs follow a valid/ready handshake. A beat is taken on a rising clock edge where both valid and ready are high. The block never applies back-pressure in normal operation. Ready is low only while reset is asserted, and it rises on the first clock edge after reset is released. A source that holds a beat while ready is low loses nothing, because that beat is neither counted nor consumed.

Top module: `rei_err_accum`

## Requirements
- R1: The error code is bits 7:4 of the status byte, with bit 7 as the MSB. In bit mode (`block_mode`=0), codes 0 to 8 add 0 to 8 to the channel's running count. Bits 3:0 have no effect.
- R2: Codes 9 to 15 add nothing in either counting mode.
- R3: In block mode (`block_mode`=1), an accepted beat whose code is 1 to 8 adds exactly 1, and code 0 adds nothing.
- R4: On an edge where `pm_tick` is high, each holding register takes the running count accumulated before that edge, and the running count restarts from zero.
- R5: A beat accepted on the same edge as `pm_tick` is counted in the new interval and is not included in the snapshot.
- R6: The holding registers are 0 after reset and do not change on any edge without `pm_tick`.
- R7: With `saturate`=0, the running count wraps modulo 2^16.
- R8: With `saturate`=1, a sum above 0xFFFF leaves the running count at 0xFFFF until the next interval pulse clears it.
- R9: Channels are independent: beats on one channel never change another channel's count.
- R10: `g1_ready` is all zeros during reset and all ones from the first edge after reset is released. A beat counts only when valid and ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| g1_valid | input | 3 | Per-channel beat valid |
| g1_byte | input | 24 | Per-channel status byte; channel i uses bits [8i+7:8i] |
| g1_ready | output | 3 | Per-channel ready |
| block_mode | input | 1 | 0 = bit counting, 1 = block counting |
| saturate | input | 1 | 0 = wrap, 1 = clamp at maximum |
| pm_tick | input | 1 | Interval pulse: snapshot and clear |
| hold_count | output | 48 | Per-channel holding register; channel i uses bits [16i+15:16i] |

## Verification
A beat or an interval pulse sampled on one edge changes the running counter on that same edge, so the running counter has one register of latency. The holding register takes the snapshot on that edge too, so `hold_count` is correct one time unit after the edge where `pm_tick` was high. `g1_ready` is correct one time unit after the first edge following reset release.

The bench drives inputs on falling edges, lets one rising edge pass, and then samples one time unit later. At that point it compares every holding register against a reference model that it advances on the same edge.

The running count is only visible through a later interval pulse. Saturation, wrap, same-edge beats and mode effects are therefore all checked in the snapshot taken by the next pulse.

// File: rtl/rei_acc_pkg.sv
package rei_acc_pkg;
  localparam int REI_MAX_CODE = 8;
  localparam int REI_VAL_W    = $clog2(REI_MAX_CODE + 1);
  typedef logic [3:0] rei_code_t;
endpackage

// File: rtl/rei_nibble_decode.sv
module rei_nibble_decode
  import rei_acc_pkg::*;
(
  input  rei_code_t              code,
  input  logic                   block_mode,
  output logic [REI_VAL_W-1:0]   add_val
);
  logic [REI_VAL_W-1:0] errs;

  always_comb begin
    if (int'(code) <= REI_MAX_CODE) errs = REI_VAL_W'(code);
    else                            errs = '0;
    if (block_mode) add_val = REI_VAL_W'(errs != '0);
    else            add_val = errs;
  end
endmodule

// File: rtl/rei_chan_acc.sv
module rei_chan_acc
  import rei_acc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  rei_code_t         code,
  input  logic              block_mode,
  input  logic              saturate,
  input  logic              pm_tick,
  output logic [CNT_W-1:0]  hold_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [REI_VAL_W-1:0] add_val;
  logic [CNT_W-1:0]     run_q, hold_q, base, run_d;
  logic [CNT_W:0]       sum;

  rei_nibble_decode u_dec (
    .code       (code),
    .block_mode (block_mode),
    .add_val    (add_val)
  );

  always_comb begin
    base = pm_tick ? '0 : run_q;
    sum  = {1'b0, base} + (accept ? (CNT_W+1)'(add_val) : '0);
    if (sum[CNT_W] && saturate) run_d = CNT_MAX;
    else                        run_d = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      hold_q <= '0;
    end else begin
      run_q <= run_d;
      if (pm_tick) hold_q <= run_q;
    end
  end

  assign hold_count = hold_q;

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_tick |=> $stable(hold_q));
  // R4
  snap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_tick && !accept) |=> (run_q == '0));
  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (saturate && !pm_tick && run_q == CNT_MAX) |=> (run_q == CNT_MAX));
  // R2
  add_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(add_val) <= REI_MAX_CODE));
  // R3
  block_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_mode |-> (add_val <= REI_VAL_W'(1)));
endmodule

// File: rtl/rei_err_accum.sv
module rei_err_accum
  import rei_acc_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        g1_valid,
  input  logic [NUM_CH*8-1:0]      g1_byte,
  output logic [NUM_CH-1:0]        g1_ready,
  input  logic                     block_mode,
  input  logic                     saturate,
  input  logic                     pm_tick,
  output logic [NUM_CH*CNT_W-1:0]  hold_count
);
  logic ready_q;
  logic [NUM_CH*4-1:0] unused_low_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign g1_ready = {NUM_CH{ready_q}};

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign unused_low_bits[i*4 +: 4] = g1_byte[i*8 +: 4];

    rei_chan_acc #(.CNT_W(CNT_W)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (g1_valid[i] & ready_q),
      .code       (g1_byte[i*8+4 +: 4]),
      .block_mode (block_mode),
      .saturate   (saturate),
      .pm_tick    (pm_tick),
      .hold_count (hold_count[i*CNT_W +: CNT_W])
    );
  end

  // R10
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> ready_q);
endmodule

// File: tb/rei_err_accum_tb.sv
module rei_err_accum_tb;
  localparam int NCH = 3;
  localparam int CW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] g1_valid = '0;
  logic [NCH*8-1:0] g1_byte = '0;
  logic [NCH-1:0] g1_ready;
  logic block_mode = 1'b0, saturate = 1'b0, pm_tick = 1'b0;
  logic [NCH*CW-1:0] hold_count;

  int checks = 0, failures = 0;
  int m_run[NCH];
  int m_hold[NCH];

  always #2 clk = ~clk;

  rei_err_accum u_dut (
    .clk(clk), .rst_n(rst_n), .g1_valid(g1_valid), .g1_byte(g1_byte),
    .g1_ready(g1_ready), .block_mode(block_mode), .saturate(saturate),
    .pm_tick(pm_tick), .hold_count(hold_count)
  );

  function automatic int decode(input logic [7:0] b, input logic blk);
    int c = int'(b[7:4]);
    int e = (c <= 8) ? c : 0;
    if (blk) return (e != 0) ? 1 : 0;
    return e;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [NCH-1:0] v, input logic [NCH*8-1:0] b,
                      input logic tick, input string tag, input bit do_chk);
    @(negedge clk);
    g1_valid = v; g1_byte = b; pm_tick = tick;
    @(posedge clk);
    for (int i = 0; i < NCH; i++) begin
      int s;
      if (tick) begin m_hold[i] = m_run[i]; m_run[i] = 0; end
      s = m_run[i] + (v[i] ? decode(b[i*8 +: 8], block_mode) : 0);
      if (s > 65535) s = saturate ? 65535 : (s & 16'hFFFF);
      m_run[i] = s;
    end
    #1;
    if (do_chk)
      for (int i = 0; i < NCH; i++)
        check(tag, int'(hold_count[i*CW +: CW]), m_hold[i]);
  endtask

  task automatic snap(input string tag);
    step('0, '0, 1'b1, tag, 1'b1);
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NCH; i++) begin m_run[i] = 0; m_hold[i] = 0; end
    #9;
    // R6 R10: reset state
    check("R6 reset hold", int'(hold_count), 0);
    check("R10 ready in reset", int'(g1_ready), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10 ready after reset", int'(g1_ready), 7);

    // R1: bit mode codes 0..8, random low nibble ignored
    for (int c = 0; c <= 8; c++) begin
      logic [7:0] bb = {4'(c), 4'($urandom)};
      step(3'b001, {16'h0, bb}, 1'b0, "R1 accumulate", 1'b0);
      snap("R1 code value");
    end

    // R2: codes 9..15 add nothing in both modes
    for (int c = 9; c <= 15; c++) begin
      step(3'b111, {3{4'(c), 4'hF}}, 1'b0, "R2 invalid", 1'b0);
    end
    snap("R2 invalid codes bit mode");
    block_mode = 1'b1;
    for (int c = 9; c <= 15; c++)
      step(3'b111, {3{4'(c), 4'h0}}, 1'b0, "R2 invalid", 1'b0);
    snap("R2 invalid codes block mode");

    // R3: block mode
    step(3'b111, {8'h80, 8'h10, 8'h00}, 1'b0, "R3", 1'b0);
    step(3'b111, {8'h50, 8'h80, 8'h00}, 1'b0, "R3", 1'b0);
    snap("R3 block counting");
    block_mode = 1'b0;

    // R5: beat on same edge as tick goes into the new interval
    step(3'b001, {16'h0, 8'h30}, 1'b0, "R5", 1'b0);
    step(3'b001, {16'h0, 8'h50}, 1'b1, "R5 snapshot excludes same-edge beat", 1'b1);
    snap("R5 same-edge beat in new interval");

    // R9: channel independence
    step(3'b010, {8'h00, 8'h70, 8'h00}, 1'b0, "R9", 1'b0);
    snap("R9 channel independence");

    // R6: hold stable while not ticking
    for (int k = 0; k < 20; k++)
      step(3'($urandom), 24'($urandom), 1'b0, "R6 hold stable", 1'b1);
    snap("R4 snapshot after stable period");

    // R7: wrap, 8193 beats of 8 on channel 2
    saturate = 1'b0;
    for (int k = 0; k < 8193; k++)
      step(3'b100, {8'h80, 16'h0}, 1'b0, "R7", 1'b0);
    snap("R7 wrap modulo 2^16");

    // R8: saturate, 8200 beats of 8 on channel 0
    saturate = 1'b1;
    for (int k = 0; k < 8200; k++)
      step(3'b001, {16'h0, 8'h80}, 1'b0, "R8", 1'b0);
    snap("R8 clamp at max");
    snap("R8 cleared after interval");
    saturate = 1'b0;

    // R4: constrained random
    for (int k = 0; k < 3000; k++) begin
      logic tk = ($urandom % 50) == 0;
      if (($urandom % 200) == 0) block_mode = ~block_mode;
      step(3'($urandom), 24'($urandom), tk, "R4 random interval", tk);
    end
    snap("R4 final snapshot");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule